// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of asynchronous input lines and turns the chosen edges on each line into a sticky pending flag. Each line has its own rising-edge and falling-edge selects. The two selects are independent, so a line can react to either edge. Each pending flag that is not masked drives a level interrupt output for that line. A second, independent mask turns qualified triggers into a one-clock event pulse on a separate output.

Software reaches the controller through a flat register interface with a single-cycle write strobe and a combinational read. That interface holds six registers: interrupt mask, event mask, rising select, falling select, software trigger and pending. A pending bit is cleared by writing 1 to it. A software trigger raises a line exactly as a hardware edge would. The trigger bit stays set until the pending bit of the same line is cleared, and that clear also removes it. The register interface is plain control with no back-pressure: every write strobe takes effect at the next clock edge, and reads never stall.

Top module: `edge_irq_ctrl`

## Requirements
- R1: There are 23 lines, and line x uses bit x of every register. Bits 31:23 always read as zero. Register selects are 0 interrupt mask, 1 event mask, 2 rising select, 3 falling select, 4 software trigger and 5 pending. Selects 6 and 7 read as zero.
- R2: `irq_o[x]` is high exactly when pending bit x and interrupt mask bit x are both 1.
- R3: When a line triggers and its event mask bit is set, `evt_o[x]` is high for exactly one clock. With the event mask bit clear, `evt_o[x]` stays low.
- R4: With only the rising select set, a 0-to-1 change on the line sets its pending bit, and a 1-to-0 change does not.
- R5: With only the falling select set, a 1-to-0 change sets the pending bit, and a 0-to-1 change does not.
- R6: With both selects set, either change sets the pending bit.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: An input change is first seen after two synchronizer clocks. The pending bit and the event pulse appear at the third rising clock edge after the change, and not at the second.
- R9: Writing 1 to a software trigger bit that reads 0 sets that trigger bit and its pending bit, and fires the event pulse if the line's event mask allows it. Writing 1 to a trigger bit that already reads 1 does nothing.
- R10: Clearing a pending bit by writing 1 also clears the software trigger bit of that line.
- R11: When an edge is detected in the same cycle as a clear write to that line's pending bit, the pending bit stays set.
- R12: After reset, all registers, `irq_o` and `evt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 23 | Asynchronous external lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| irq_o | output | 23 | Per-line level interrupt |
| evt_o | output | 23 | Per-line one-clock event pulse |

## Verification
The assertions assume that `cfg_addr` and `cfg_wdata` are stable whenever `cfg_we` is high. They also assume that reset is held long enough to flush the synchronizer. The bench keeps every line low during reset, so that no spurious rising edge appears at release. It changes lines and register strobes only on the falling clock edge. The coincident edge-and-clear case is produced by starting the write exactly two clocks after the line changes. That places the write in the cycle where the edge is detected.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_IMASK = 3'd0,
    SEL_EMASK = 3'd1,
    SEL_RISE  = 3'd2,
    SEL_FALL  = 3'd3,
    SEL_SWTRG = 3'd4,
    SEL_PEND  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned W      = 23,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= async_i;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge #(
  parameter int unsigned W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  always_comb begin
    hit_o = ( lvl_i & ~prev_q & rise_en_i)
          | (~lvl_i &  prev_q & fall_en_i);
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned N  = 23,
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N-1:0]     hit_i,
  output logic [N-1:0]     imask_o,
  output logic [N-1:0]     rise_o,
  output logic [N-1:0]     fall_o,
  output logic [N-1:0]     pend_o,
  output logic [N-1:0]     swtrg_o,
  output logic [N-1:0]     evt_o
);
  localparam int unsigned PADW = DW - N;

  logic [N-1:0] imask_q, emask_q, rise_q, fall_q, swtrg_q, pend_q, evt_q;
  logic [N-1:0] wd, sw_set, clr, trig;
  logic         unused_hi;

  assign wd        = wdata_i[N-1:0];
  assign unused_hi = ^wdata_i[DW-1:N];

  always_comb begin
    sw_set = (we_i && addr_i == SEL_SWTRG) ? (wd & ~swtrg_q) : '0;
    clr    = (we_i && addr_i == SEL_PEND)  ? wd : '0;
    trig   = hit_i | sw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      swtrg_q <= '0;
      pend_q  <= '0;
      evt_q   <= '0;
    end else begin
      if (we_i && addr_i == SEL_IMASK) imask_q <= wd;
      if (we_i && addr_i == SEL_EMASK) emask_q <= wd;
      if (we_i && addr_i == SEL_RISE)  rise_q  <= wd;
      if (we_i && addr_i == SEL_FALL)  fall_q  <= wd;
      swtrg_q <= (swtrg_q | sw_set) & ~clr;
      pend_q  <= (pend_q & ~clr) | trig;
      evt_q   <= trig & emask_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_IMASK: rdata_o = {{PADW{1'b0}}, imask_q};
      SEL_EMASK: rdata_o = {{PADW{1'b0}}, emask_q};
      SEL_RISE:  rdata_o = {{PADW{1'b0}}, rise_q};
      SEL_FALL:  rdata_o = {{PADW{1'b0}}, fall_q};
      SEL_SWTRG: rdata_o = {{PADW{1'b0}}, swtrg_q};
      SEL_PEND:  rdata_o = {{PADW{1'b0}}, pend_q};
      default:   rdata_o = '0;
    endcase
  end

  assign imask_o = imask_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign pend_o  = pend_q;
  assign swtrg_o = swtrg_q;
  assign evt_o   = evt_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned N_LINES     = 23,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  output logic [N_LINES-1:0] irq_o,
  output logic [N_LINES-1:0] evt_o
);
  logic [N_LINES-1:0] line_s, edge_hit, imask, rise_sel, fall_sel, pend, swtrg;

  eirq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(line_i), .sync_o(line_s)
  );

  eirq_edge #(.W(N_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(line_s),
    .rise_en_i(rise_sel), .fall_en_i(fall_sel), .hit_o(edge_hit)
  );

  eirq_regs #(.N(N_LINES), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .hit_i(edge_hit),
    .imask_o(imask), .rise_o(rise_sel), .fall_o(fall_sel),
    .pend_o(pend), .swtrg_o(swtrg), .evt_o(evt_o)
  );

  assign irq_o = pend & imask;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int unsigned N  = 23,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic [DW-1:0] cfg_rdata,
  input logic [N-1:0]  irq_o,
  input logic [N-1:0]  evt_o,
  input logic [N-1:0]  edge_hit,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  swtrg,
  input logic [N-1:0]  imask
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DW-1:N] == '0);

  a_r2_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~imask) == '0);

  a_r4_edge_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> (pend & $past(edge_hit)) == $past(edge_hit));

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd5)
    |=> (pend & $past(cfg_wdata[N-1:0]) & ~$past(edge_hit)) == '0);

  a_r9_sw_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd4)
    |=> (pend & ($past(cfg_wdata[N-1:0]) & ~$past(swtrg)))
        == ($past(cfg_wdata[N-1:0]) & ~$past(swtrg)));

  a_r10_clear_drops_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd5) |=> (swtrg & $past(cfg_wdata[N-1:0])) == '0);

  a_r3_evt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |-> ($past(|edge_hit) || $past(cfg_we && cfg_addr == 3'd4)));
endmodule

bind edge_irq_ctrl eirq_checker #(.N(N_LINES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_o(irq_o), .evt_o(evt_o),
  .edge_hit(edge_hit), .pend(pend), .swtrg(swtrg), .imask(imask)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
  localparam int N = 23;
  localparam logic [2:0] A_IM = 3'd0, A_EM = 3'd1, A_RI = 3'd2,
                         A_FA = 3'd3, A_SW = 3'd4, A_PD = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  line_i = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [N-1:0]  irq_o, evt_o;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic drive_settle(input int ln, input logic v);
    @(negedge clk); line_i[ln] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d); chk("R12 reset reg", d, 32'h0);
    end
    chk("R12 reset irq", {9'h0, irq_o}, 32'h0);
    chk("R12 reset evt", {9'h0, evt_o}, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(A_IM, 32'h7FFFFF); wr(A_EM, 32'h8); wr(A_RI, 32'h8);
    @(negedge clk); line_i[3] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(A_PD, d); chk("R8 not yet pending", d, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(A_PD, d); chk("R4 rising sets pending", d, 32'h8);
    chk("R8 event on third edge", {9'h0, evt_o}, 32'h8);
    chk("R2 irq follows pending", {9'h0, irq_o}, 32'h8);
    @(negedge clk);
    chk("R3 event one clock", {9'h0, evt_o}, 32'h0);
    wr(A_PD, 32'h8);
    rd(A_PD, d); chk("R7 w1c clears", d, 32'h0);
    drive_settle(3, 1'b0);
    rd(A_PD, d); chk("R4 falling ignored", d, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(A_FA, 32'h20);
    drive_settle(5, 1'b1);
    rd(A_PD, d); chk("R5 rising ignored", d, 32'h0);
    drive_settle(5, 1'b0);
    rd(A_PD, d); chk("R5 falling sets", d, 32'h20);
    chk("R3 masked event stays low", {9'h0, evt_o}, 32'h0);
    wr(A_PD, 32'h20);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(A_RI, 32'h88); wr(A_FA, 32'h80);
    drive_settle(7, 1'b1);
    rd(A_PD, d); chk("R6 rise with both", d, 32'h80);
    wr(A_PD, 32'h80);
    drive_settle(7, 1'b0);
    rd(A_PD, d); chk("R6 fall with both", d, 32'h80);
    wr(A_PD, 32'h80);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_IM, 32'h0); wr(A_RI, 32'h200);
    drive_settle(9, 1'b1);
    rd(A_PD, d); chk("R2 pending while masked", d, 32'h200);
    chk("R2 masked irq low", {9'h0, irq_o}, 32'h0);
    wr(A_IM, 32'h200);
    chk("R2 unmask raises irq", {9'h0, irq_o}, 32'h200);
    wr(A_PD, 32'h0);
    rd(A_PD, d); chk("R7 write 0 no effect", d, 32'h200);
    wr(A_PD, 32'h200);
    chk("R7 clear drops irq", {9'h0, irq_o}, 32'h0);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr(A_EM, 32'h1000);
    wr(A_SW, 32'h1000);
    chk("R9 sw event pulse", {9'h0, evt_o}, 32'h1000);
    rd(A_PD, d); chk("R9 sw sets pending", d, 32'h1000);
    rd(A_SW, d); chk("R9 sw bit reads 1", d, 32'h1000);
    @(negedge clk);
    chk("R3 sw event one clock", {9'h0, evt_o}, 32'h0);
    wr(A_SW, 32'h1000);
    chk("R9 repeat write no event", {9'h0, evt_o}, 32'h0);
    wr(A_PD, 32'h1000);
    rd(A_SW, d); chk("R10 clear drops sw bit", d, 32'h0);
    rd(A_PD, d); chk("R10 pending cleared", d, 32'h0);
  endtask

  task automatic t_edge_wins();
    logic [31:0] d;
    wr(A_RI, 32'h8000);
    @(negedge clk); line_i[15] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = A_PD; cfg_wdata = 32'h8000;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    rd(A_PD, d); chk("R11 edge beats clear", d, 32'h8000);
    wr(A_PD, 32'h8000);
  endtask

  task automatic t_upper();
    logic [31:0] d;
    wr(A_FA, 32'hFFFFFFFF);
    rd(A_FA, d); chk("R1 upper bits zero", d, 32'h007FFFFF);
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd6, d); chk("R1 unused select zero", d, 32'h0);
    rd(3'd7, d); chk("R1 select 7 zero", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_mask();
    t_sw();
    t_edge_wins();
    t_upper();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule